// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

The block switches 8-bit time slots between a small set of TDM streams. On the receive side each byte arrives with its stream and channel number and is stored in a data memory with two banks. A frame-start strobe swaps the banks. On the transmit side the output sequencer names a stream and channel. The block then fetches that slot's 16-bit connection word and, two clocks later, delivers the byte for the slot. That byte can be switched data copied from any stored source slot, a constant byte carried in the connection word, or nothing at all, in which case the slot's driver enable is deasserted.

Each connection word also selects a delay mode for its slot. In variable mode the slot takes data already written in the current frame. In constant mode it takes data from the previous frame. A loopback flag makes the byte a slot transmits become that same slot's received data. The stream and channel counts are parameters and must be powers of two. A simple write port loads the connection words.

Top module: `tsi_switch`

## Requirements
- R1: A request sampled on a clock edge produces `out_valid` high two edges later, for exactly one cycle. `out_valid` is low one edge after the request.
- R2: When connection word bit 12 (enable) is 0, the slot reports `out_oe` low and `out_data` 0x00, whatever the other bits hold.
- R3: When bit 13 is 1 and bit 12 is 1, `out_data` equals bits 7:0 of the connection word (constant byte mode).
- R4: When bit 13 is 0, the source slot is named by bits 6:0 (channel; the low log2(NCHAN) bits are used) and bits 11:7 (stream; the low log2(NSTREAM) bits are used), and `out_data` is the byte stored for that slot.
- R5: With bit 14 at 0 (variable delay), a switched slot reads the bank currently being written, so a byte written earlier in the same frame is returned.
- R6: With bit 14 at 1 (constant delay), a switched slot reads the other bank, so the byte written during the previous frame is returned.
- R7: Every `frame_start` pulse swaps the write bank. Without a pulse the bank stays put.
- R8: When bit 15 (loopback) of the word for slot (n,m) is 1, each byte that slot transmits is written into the current bank at (n,m). Receive bytes addressed to (n,m) are ignored while the flag is set.
- R9: After reset every connection word and every stored byte is zero, so every slot transmits with `out_oe` low, and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Single-cycle strobe that swaps data memory banks |
| in_valid | input | 1 | Receive byte present |
| in_stream | input | log2(NSTREAM) | Receive stream number |
| in_chan | input | log2(NCHAN) | Receive channel number |
| in_data | input | 8 | Receive byte |
| cm_we | input | 1 | Connection word write strobe |
| cm_addr | input | log2(NSTREAM)+log2(NCHAN) | Output slot index {stream, channel} |
| cm_wdata | input | 16 | Connection word |
| out_req | input | 1 | Output slot request |
| out_stream | input | log2(NSTREAM) | Requested output stream |
| out_chan | input | log2(NCHAN) | Requested output channel |
| out_valid | output | 1 | Output byte ready |
| out_oe | output | 1 | Driver enable for the slot (low means high impedance) |
| out_data | output | 8 | Output byte |

## Verification
The assertions assume that `out_req` and `frame_start` are held low during reset. They also assume that `frame_start` is the only thing that moves the write bank, so a bank flip with no strobe is a fault. The bench drives every input on the falling edge, raises each request and strobe for a single cycle, and never writes a connection word in the same cycle a request for that slot is in flight. This keeps the two-clock pipeline and the bank sequence well defined for every check.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NSTREAM = 4,
  parameter int NCHAN   = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   frame_start,
  input  logic                                   in_valid,
  input  logic [$clog2(NSTREAM)-1:0]             in_stream,
  input  logic [$clog2(NCHAN)-1:0]               in_chan,
  input  logic [7:0]                             in_data,
  input  logic                                   cm_we,
  input  logic [$clog2(NSTREAM)+$clog2(NCHAN)-1:0] cm_addr,
  input  logic [15:0]                            cm_wdata,
  input  logic                                   out_req,
  input  logic [$clog2(NSTREAM)-1:0]             out_stream,
  input  logic [$clog2(NCHAN)-1:0]               out_chan,
  output logic                                   out_valid,
  output logic                                   out_oe,
  output logic [7:0]                             out_data
);
  localparam int SW    = $clog2(NSTREAM);
  localparam int CW    = $clog2(NCHAN);
  localparam int AW    = SW + CW;
  localparam int SLOTS = 1 << AW;

  logic [15:0]      cmem [SLOTS];
  logic [7:0]       dmem [2*SLOTS];
  logic [SLOTS-1:0] lb_map;
  logic             wbank;

  logic             s1_valid;
  logic [AW-1:0]    s1_slot;
  logic [15:0]      s1_word;

  logic [AW-1:0] in_slot, src_slot;
  logic          rd_bank, lb_fire;
  logic [7:0]    sw_byte, tx_byte;
  logic          unused_bits;

  assign in_slot  = {in_stream, in_chan};
  assign src_slot = {s1_word[7 +: SW], s1_word[0 +: CW]};
  assign rd_bank  = s1_word[14] ? ~wbank : wbank;
  assign sw_byte  = dmem[{rd_bank, src_slot}];
  assign tx_byte  = !s1_word[12] ? 8'h00 :
                    s1_word[13]  ? s1_word[7:0] : sw_byte;
  assign lb_fire  = s1_valid && s1_word[15];
  assign unused_bits = ^s1_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) cmem[i] <= '0;
      lb_map <= '0;
    end else if (cm_we) begin
      cmem[cm_addr]   <= cm_wdata;
      lb_map[cm_addr] <= cm_wdata[15];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbank <= 1'b0;
    end else if (frame_start) begin
      wbank <= ~wbank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*SLOTS; i++) dmem[i] <= '0;
    end else begin
      if (in_valid && !lb_map[in_slot])
        dmem[{wbank, in_slot}] <= in_data;
      if (lb_fire)
        dmem[{wbank, s1_slot}] <= tx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_slot  <= '0;
      s1_word  <= '0;
    end else begin
      s1_valid <= out_req;
      s1_slot  <= {out_stream, out_chan};
      s1_word  <= cmem[{out_stream, out_chan}];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_oe    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_oe    <= s1_valid && s1_word[12];
      out_data  <= s1_valid ? tx_byte : 8'h00;
    end
  end
endmodule

module tsi_switch_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       out_req,
  input logic       out_valid,
  input logic       out_oe,
  input logic [7:0] out_data,
  input logic       wbank,
  input logic       s1_valid
);
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> ##1 out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid));
  a_r2_off_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_oe) |-> (out_data == 8'h00));
  a_r7_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (wbank != $past(wbank)));
  a_r7_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(wbank));
endmodule

bind tsi_switch tsi_switch_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .out_req(out_req),
  .out_valid(out_valid), .out_oe(out_oe), .out_data(out_data),
  .wbank(wbank), .s1_valid(s1_valid)
);

// File: tb/tsi_switch_test.sv
`timescale 1ns/1ps
module tsi_switch_test;
  logic clk = 0, rst_n = 0, frame_start = 0, in_valid = 0, cm_we = 0, out_req = 0;
  logic [1:0] in_stream = 0, out_stream = 0;
  logic [4:0] in_chan = 0, out_chan = 0;
  logic [7:0] in_data = 0;
  logic [6:0] cm_addr = 0;
  logic [15:0] cm_wdata = 0;
  logic out_valid, out_oe;
  logic [7:0] out_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tsi_switch uut (.*);

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cm(int s, int c, logic [15:0] w);
    @(negedge clk); cm_we = 1; cm_addr = 7'(s*32 + c); cm_wdata = w;
    @(negedge clk); cm_we = 0;
  endtask

  task automatic wr_in(int s, int c, logic [7:0] d);
    @(negedge clk); in_valid = 1; in_stream = 2'(s); in_chan = 5'(c); in_data = d;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic frame;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic request(string req, int s, int c, logic oe, logic [7:0] d);
    @(negedge clk); out_req = 1; out_stream = 2'(s); out_chan = 5'(c);
    @(negedge clk); out_req = 0;
    check("R1 mid", {8'h0, out_valid}, 9'h0);
    @(negedge clk);
    check("R1 valid", {8'h0, out_valid}, 9'h1);
    check(req, {oe ? 1'b1 : 1'b0, d}, {out_oe, out_data});
    @(negedge clk);
    check("R1 one cycle", {8'h0, out_valid}, 9'h0);
  endtask

  task automatic t_reset;
    check("R9 valid low", {8'h0, out_valid}, 9'h0);
    request("R9 tristate", 0, 0, 0, 8'h00);
    wr_cm(0, 2, 16'h1081);
    request("R9 memory zero", 0, 2, 1, 8'h00);
  endtask

  task automatic t_message;
    wr_cm(2, 5, 16'h30A5);
    request("R3 constant byte", 2, 5, 1, 8'hA5);
    wr_cm(2, 5, 16'h20A5);
    request("R2 constant byte disabled", 2, 5, 0, 8'h00);
  endtask

  task automatic t_switched;
    wr_in(1, 3, 8'h3C);
    wr_cm(0, 2, 16'h1083);
    request("R5 R4 same frame", 0, 2, 1, 8'h3C);
    wr_in(2, 31, 8'hE1);
    wr_cm(1, 0, 16'h111F);
    request("R4 last channel", 1, 0, 1, 8'hE1);
  endtask

  task automatic t_delay;
    frame;
    wr_in(2, 7, 8'h11);
    frame;
    wr_in(2, 7, 8'h22);
    wr_cm(1, 1, 16'h5107);
    wr_cm(1, 2, 16'h1107);
    request("R6 constant previous frame", 1, 1, 1, 8'h11);
    request("R5 variable current frame", 1, 2, 1, 8'h22);
    frame;
    request("R7 constant after swap", 1, 1, 1, 8'h22);
    request("R7 variable after swap", 1, 2, 1, 8'h11);
    wr_cm(1, 3, 16'h0107);
    request("R2 switched disabled", 1, 3, 0, 8'h00);
  endtask

  task automatic t_loopback;
    wr_cm(3, 4, 16'hB077);
    request("R8 transmit", 3, 4, 1, 8'h77);
    wr_in(3, 4, 8'h99);
    wr_cm(0, 0, 16'h1184);
    request("R8 looped byte kept", 0, 0, 1, 8'h77);
    frame;
    wr_cm(0, 1, 16'h5184);
    request("R8 looped byte previous frame", 0, 1, 1, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_message;
    t_switched;
    t_delay;
    t_loopback;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule